// File: doc/BRIEF.md
# Network-Side Line Activation Controller

This block sits on the network-termination end of a four-wire subscriber line. It decides how the link is brought up and taken down. It keeps a four-state link state. From that state it chooses the line signal code the transmitter sends:

- Info0: silence.
- Info2: an all-zero framed signal.
- Info4: a framed signal carrying traffic, with the activation bit set.

Host software drives an activation request and a deactivation request. The receiver reports whether it has frame lock. When the link is being released, a countdown holds the line silent for a fixed 32 ms before the block returns to idle.

A single status bit is offered back to the host. While activation is requested and deactivation is not, the bit shows receive frame lock. Otherwise it shows line bus activity. The choice of meaning is latched only on the first cycle of each serial frame, so a request change alters the bit's meaning from the following frame on.

A configuration input tells the receive front end which wiring applies. Fixed receive timing suits a short bus. Adaptive timing suits point-to-point or long-reach wiring. The block registers this choice as an enable for adaptive receive tracking.

Top module: `nt_link_activation`

## Requirements
- R1: A synchronous active-high `rst` sets the following, on the clock edge where it is sampled:
  - `link_state` to idle (0);
  - `tx_info_code` to 3'b000;
  - `status_is_sync` to 0;
  - `rx_adaptive_en` to 0.
- R2: In idle (0), a cycle with `host_act_req`=1 and `host_deact_req`=0 moves to arming (1) on the next edge. In any other idle cycle the state stays idle. This includes a cycle with both requests high, and a cycle with `rx_frame_lock` high.
- R3: In arming (1) with no deactivation request, `rx_frame_lock`=1 moves to link-up (2). Without lock, the state stays arming.
- R4: In arming or link-up, `host_deact_req`=1 moves to draining (3) on the next edge. This takes priority over `host_act_req` and over `rx_frame_lock`.
- R5: Draining lasts exactly DRAIN_TICKS = (CLK_HZ/1,000,000)·DRAIN_US clock cycles after entry and then returns to idle.
  - During draining, requests and lock are ignored.
  - The count restarts from zero on every entry.
- R6: `tx_info_code` is 3'b000 (Info0) in idle and draining, 3'b010 (Info2) in arming, and 3'b100 (Info4) in link-up.
- R7: `link_state` encodes idle=0, arming=1, link-up=2, draining=3.
- R8: On each edge where `frame_start`=1, `status_is_sync` takes the value of `host_act_req` AND NOT `host_deact_req`. On any other edge it holds.
- R9: `status_bit` equals `rx_frame_lock` while `status_is_sync`=1, and `rx_bus_activity` while it is 0. It follows those inputs within the same cycle.
- R10: `rx_adaptive_en` is the inverse of `cfg_fixed_timing`, registered with one cycle of latency.
- R11: Link-up holds for as long as no deactivation request arrives, even if `host_act_req` or `rx_frame_lock` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fixed_timing | input | 1 | 1 selects fixed receive timing, 0 selects adaptive |
| host_act_req | input | 1 | Host activation request |
| host_deact_req | input | 1 | Host deactivation request |
| rx_frame_lock | input | 1 | Receiver has frame lock |
| rx_bus_activity | input | 1 | Receiver sees signal on the line |
| frame_start | input | 1 | One-cycle pulse at the start of each serial frame |
| tx_info_code | output | 3 | Line signal code to transmit |
| link_state | output | 2 | Current link state |
| status_bit | output | 1 | Shared lock / activity status |
| status_is_sync | output | 1 | Current meaning of status_bit (1 = frame lock) |
| rx_adaptive_en | output | 1 | Enable for adaptive receive tracking |

## Verification
The bench builds the block with CLK_HZ = 1,000,000 and DRAIN_US = 20, which gives a 20-cycle drain window. At the default parameters the 32 ms window would take 1.6 million cycles. The short window lets the bench walk the whole drain twice and check the exact cycle of return to idle each time. In the second drain it shows the count restarting from zero. It also shows that deactivation and activation requests toggled inside the window change nothing. Frame pulses are placed both inside and outside request changes, to show the delayed switch of the status bit's meaning.

// File: rtl/nt_act_pkg.sv
`timescale 1ns/1ps
package nt_act_pkg;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_ARMING = 2'd1,
        LS_UP     = 2'd2,
        LS_DRAIN  = 2'd3
    } link_state_e;

    typedef enum logic [2:0] {
        TX_INFO0 = 3'b000,
        TX_INFO2 = 3'b010,
        TX_INFO4 = 3'b100
    } tx_code_e;

    typedef struct packed {
        link_state_e state;
    } fsm_regs_t;

    typedef struct packed {
        logic sel_sync;
    } sel_regs_t;

    typedef struct packed {
        logic adapt_en;
    } cfg_regs_t;

endpackage

// File: rtl/nt_drain_timer.sv
`timescale 1ns/1ps
module nt_drain_timer #(
    parameter int unsigned TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = run && (tmr_q.cnt == LAST);
        if (run && !expire) begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end else begin
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_q.cnt <= LAST);

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> tmr_q.cnt == '0);

endmodule

// File: rtl/nt_link_fsm.sv
`timescale 1ns/1ps
module nt_link_fsm
    import nt_act_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        act_req,
    input  logic        deact_req,
    input  logic        frame_lock,
    input  logic        drain_done,
    output link_state_e state
);
    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            LS_IDLE: begin
                if (act_req && !deact_req) fsm_d.state = LS_ARMING;
            end
            LS_ARMING: begin
                if (deact_req)       fsm_d.state = LS_DRAIN;
                else if (frame_lock) fsm_d.state = LS_UP;
            end
            LS_UP: begin
                if (deact_req) fsm_d.state = LS_DRAIN;
            end
            LS_DRAIN: begin
                if (drain_done) fsm_d.state = LS_IDLE;
            end
            default: fsm_d.state = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.state <= LS_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.state;

    // R2
    idle_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.state == LS_IDLE) && act_req && !deact_req |=> fsm_q.state == LS_ARMING);

    // R3
    arm_up_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.state == LS_ARMING) && frame_lock && !deact_req |=> fsm_q.state == LS_UP);

    // R4
    deact_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.state inside {LS_ARMING, LS_UP}) && deact_req |=> fsm_q.state == LS_DRAIN);

    // R5
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.state == LS_DRAIN) && !drain_done |=> fsm_q.state == LS_DRAIN);

    // R11
    up_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.state == LS_UP) && !deact_req |=> fsm_q.state == LS_UP);

endmodule

// File: rtl/nt_status_select.sv
`timescale 1ns/1ps
module nt_status_select
    import nt_act_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act_req,
    input  logic deact_req,
    input  logic frame_start,
    input  logic frame_lock,
    input  logic bus_activity,
    output logic sel_sync,
    output logic status_bit
);
    sel_regs_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (frame_start) begin
            sel_d.sel_sync = act_req && !deact_req;
        end
        status_bit = sel_q.sel_sync ? frame_lock : bus_activity;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_sync = sel_q.sel_sync;

    // R8
    sel_capture_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> sel_q.sel_sync == $past(act_req && !deact_req));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(sel_q.sel_sync));

endmodule

// File: rtl/nt_tx_encode.sv
`timescale 1ns/1ps
module nt_tx_encode
    import nt_act_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  link_state_e state,
    output tx_code_e    code
);
    always_comb begin
        unique case (state)
            LS_ARMING: code = TX_INFO2;
            LS_UP:     code = TX_INFO4;
            default:   code = TX_INFO0;
        endcase
    end

    // R6
    code_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(code));

endmodule

// File: rtl/nt_link_activation.sv
`timescale 1ns/1ps
module nt_link_activation
    import nt_act_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned DRAIN_US = 32_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_fixed_timing,
    input  logic       host_act_req,
    input  logic       host_deact_req,
    input  logic       rx_frame_lock,
    input  logic       rx_bus_activity,
    input  logic       frame_start,
    output logic [2:0] tx_info_code,
    output logic [1:0] link_state,
    output logic       status_bit,
    output logic       status_is_sync,
    output logic       rx_adaptive_en
);
    localparam int unsigned TICKS_PER_US = CLK_HZ / 32'd1_000_000;
    localparam int unsigned DRAIN_TICKS  = TICKS_PER_US * DRAIN_US;

    link_state_e state;
    tx_code_e    code;
    logic        drain_done;
    cfg_regs_t   cfg_d, cfg_q;

    nt_link_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .act_req    (host_act_req),
        .deact_req  (host_deact_req),
        .frame_lock (rx_frame_lock),
        .drain_done (drain_done),
        .state      (state)
    );

    nt_drain_timer #(.TICKS(DRAIN_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == LS_DRAIN),
        .expire (drain_done)
    );

    nt_status_select u_sel (
        .clk          (clk),
        .rst          (rst),
        .act_req      (host_act_req),
        .deact_req    (host_deact_req),
        .frame_start  (frame_start),
        .frame_lock   (rx_frame_lock),
        .bus_activity (rx_bus_activity),
        .sel_sync     (status_is_sync),
        .status_bit   (status_bit)
    );

    nt_tx_encode u_enc (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .code  (code)
    );

    always_comb begin
        cfg_d          = cfg_q;
        cfg_d.adapt_en = !cfg_fixed_timing;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign tx_info_code   = code;
    assign link_state     = state;
    assign rx_adaptive_en = cfg_q.adapt_en;

    // R10
    adapt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rx_adaptive_en == !$past(cfg_fixed_timing));

    // R6
    info4_only_up_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_info_code == 3'b100) |-> (link_state == 2'd2));

endmodule

// File: tb/nt_link_activation_test.sv
`timescale 1ns/1ps
module nt_link_activation_test;

    localparam int unsigned TB_CLK_HZ = 1_000_000;
    localparam int unsigned TB_US     = 20;
    localparam int          TB_TICKS  = 20;
    localparam logic [1:0]  S_IDLE = 2'd0, S_ARM = 2'd1, S_UP = 2'd2, S_DRAIN = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_fixed_timing = 1'b0;
    logic host_act_req = 1'b0;
    logic host_deact_req = 1'b0;
    logic rx_frame_lock = 1'b0;
    logic rx_bus_activity = 1'b0;
    logic frame_start = 1'b0;
    logic [2:0] tx_info_code;
    logic [1:0] link_state;
    logic status_bit, status_is_sync, rx_adaptive_en;

    int n_tests = 0;
    int n_fail  = 0;
    logic exp_sel = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] st;
        logic       sel;
        logic       lock;
        logic       act;
        logic       adapt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    nt_link_activation #(.CLK_HZ(TB_CLK_HZ), .DRAIN_US(TB_US)) uut (
        .clk(clk), .rst(rst), .cfg_fixed_timing(cfg_fixed_timing),
        .host_act_req(host_act_req), .host_deact_req(host_deact_req),
        .rx_frame_lock(rx_frame_lock), .rx_bus_activity(rx_bus_activity),
        .frame_start(frame_start), .tx_info_code(tx_info_code),
        .link_state(link_state), .status_bit(status_bit),
        .status_is_sync(status_is_sync), .rx_adaptive_en(rx_adaptive_en)
    );

    // R6 code table
    function automatic logic [2:0] code_for(input logic [1:0] st);
        case (st)
            S_ARM:   return 3'b010;
            S_UP:    return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic step(input logic r, input logic a, input logic d, input logic s,
                        input logic b, input logic f, input logic c,
                        input logic [1:0] est, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; host_act_req = a; host_deact_req = d; rx_frame_lock = s;
        rx_bus_activity = b; frame_start = f; cfg_fixed_timing = c;
        if (r) exp_sel = 1'b0;
        else if (f) exp_sel = a && !d;
        e.st = est; e.sel = exp_sel; e.lock = s; e.act = b;
        e.adapt = r ? 1'b0 : !c;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares outputs shortly after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic exp_stat;
                e = exp_q.pop_front();
                exp_stat = e.sel ? e.lock : e.act;
                n_tests++;
                if (link_state !== e.st || tx_info_code !== code_for(e.st) ||
                    status_is_sync !== e.sel || status_bit !== exp_stat ||
                    rx_adaptive_en !== e.adapt) begin
                    n_fail++;
                    $display("FAIL %s: state=%0d/%0d code=%b/%b sel=%b/%b stat=%b/%b adapt=%b/%b",
                             e.tag, link_state, e.st, tx_info_code, code_for(e.st),
                             status_is_sync, e.sel, status_bit, exp_stat,
                             rx_adaptive_en, e.adapt);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state; R7 idle encoding
        step(1,0,0,0,0,0,0, S_IDLE, "R1 reset");
        step(1,1,0,1,1,1,0, S_IDLE, "R1 reset holds");
        step(0,0,0,0,1,0,0, S_IDLE, "R9 activity shown");
        step(0,0,0,0,0,0,1, S_IDLE, "R10 fixed timing");
        step(0,0,0,0,0,0,0, S_IDLE, "R10 adaptive timing");
        step(0,1,1,1,0,1,0, S_IDLE, "R2 deact blocks act");
        step(0,0,0,1,0,0,0, S_IDLE, "R2 lock ignored in idle");
        step(0,1,0,0,1,0,0, S_ARM,  "R2 act arms, R8 old meaning");
        step(0,1,0,0,1,1,0, S_ARM,  "R3 waits for lock, R8 new meaning");
        step(0,1,0,0,0,0,1, S_ARM,  "R3 still arming");
        step(0,1,0,1,0,0,0, S_UP,   "R3 lock brings link up");
        step(0,0,0,0,1,0,0, S_UP,   "R11 up holds, R8 meaning held");
        step(0,0,0,1,0,1,0, S_UP,   "R8 capture on frame, R9 activity");
        step(0,1,1,1,1,0,0, S_DRAIN,"R4 deact wins over act");
        for (int i = 1; i < TB_TICKS; i++)
            step(0, 1, i[1], 1, i[0], (i == 5), 0, S_DRAIN, "R5 drain hold");
        step(0,1,0,1,0,0,0, S_IDLE, "R5 drain expiry");
        step(0,1,0,0,0,0,0, S_ARM,  "R2 rearm");
        step(0,0,0,0,1,0,0, S_ARM,  "R3 no lock");
        step(0,0,1,1,0,0,0, S_DRAIN,"R4 deact wins over lock");
        for (int i = 1; i < TB_TICKS; i++)
            step(0, i[0], !i[0], 1, 0, 0, 0, S_DRAIN, "R5 restart hold");
        step(0,0,0,0,1,0,0, S_IDLE, "R5 restart expiry");
        step(0,0,0,1,1,1,0, S_IDLE, "R7 idle, R9 after capture");
        step(1,1,0,0,0,0,0, S_IDLE, "R1 reset mid-run");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule